// File: doc/BRIEF.md
# Reloadable Transfer Counter

This block holds the byte-count state for a DMA-driven data phase. The host programs the count one byte at a time through a byte-wide register port. Each write lands in a shadow register, so the count in use is not disturbed. A command write with its DMA flag set loads the shadows into the live counter. The live counter then counts down one step for each byte the DMA engine reports as moved. It raises a terminal-count flag when it reaches zero. A done input from the DMA engine ends the transfer early and leaves the block in its completion state.

Two lengths are offered to the DMA engine. The first is the effective count, where a live value of zero stands for 65536 bytes. The second is the length that will actually move, which is the smaller of the effective count and the data size still to be delivered. The top byte of the count doubles as an identification register. It returns a fixed code until the host first writes that byte after reset. A one-cycle clear pulse tells neighbouring logic to zero its FIFO flags and its sequence step when a transfer completes.

Top module: `xcnt_top`

## Requirements
- R1: The live count is assembled with address 0 as bits 7:0, address 1 as bits 15:8 and address 2 as bits 23:16. Reading addresses 0 to 2 returns the matching live byte.
- R2: A host write to address 0, 1 or 2 changes only the shadow byte. The live count read back at those addresses is unchanged by the write.
- R3: A write to the command address 3 with bit 7 set copies all three shadow bytes into the live count at the same clock edge. It also clears the terminal-count flag and sets the interrupt code to 0. A command write with bit 7 clear leaves the live count unchanged.
- R4: `eff_len_o` equals the live count, except that a live count of zero gives 65536 (0x010000).
- R5: `xfer_len_o` equals the smaller of `eff_len_o` and `rem_size`.
- R6: A write to any of the count addresses 0 to 2 clears the terminal-count flag. The flag is seen on `term_cnt_o` and as bit 4 of the status register at address 4.
- R7: After reset, reading address 2 returns the parameter CHIP_ID (default 0xA2). This holds until address 2 is written once. After that, the read returns the live high byte. Writes to addresses 0 and 1 do not end the identification read.
- R8: A one-cycle `xfer_done` zeroes the live count, sets the terminal-count flag and sets the interrupt code to bus-service (0x10). The interrupt code is readable at address 5. `side_clr_o` is high for exactly the following cycle.
- R9: Each cycle with `dec_req` high and a non-zero live count lowers the count by one. When the count steps from 1 to 0, `term_cnt_o` rises at the same edge at which the count reads zero.
- R10: `dec_req` has no effect while the live count is zero. The count stays at zero and the flag stays set.
- R11: Reset, synchronous and active low, leaves the live count and the shadow bytes at zero. It also clears the terminal-count flag, the interrupt code, `side_clr_o` and the written-once state of the high byte.
- R12: In a single cycle, a DMA reload takes priority over `xfer_done`, and `xfer_done` takes priority over `dec_req`. An `xfer_done` that loses to a reload has no effect at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0-2 count, 3 command, 4 status, 5 interrupt) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| dec_req | input | 1 | One byte moved; decrement the live count |
| xfer_done | input | 1 | DMA transfer finished |
| rem_size | input | 24 | Data still to be delivered by the other side |
| eff_len_o | output | 24 | Effective count (zero means 65536) |
| xfer_len_o | output | 24 | Length that will move: min(eff_len_o, rem_size) |
| term_cnt_o | output | 1 | Terminal count / transfer complete |
| intr_code_o | output | 8 | Interrupt code register |
| side_clr_o | output | 1 | One-cycle pulse to zero FIFO flags and sequence step |

## Verification
Any corruption of the live count shows on `eff_len_o` and `xfer_len_o` in the cycle after the edge that caused it, because both are combinational from the counter. It shows on the count read-back at the same time. A stray write into the live copy instead of the shadow is therefore visible one edge after the write. A wrongly held or dropped terminal-count flag shows on `term_cnt_o` and on status bit 4 right after the edge that should have changed it. An error in the written-once state of the high byte stays hidden until address 2 is read, so the bench reads that byte before and after each kind of write.

// File: rtl/xcnt_pkg.sv
// Shared constants for the reloadable transfer counter.
// Assumes byte-wide registers; address map beyond the count bytes is derived in the top.
package xcnt_pkg;
    localparam int BYTE_W       = 8;
    localparam int CMD_DMA_BIT  = 7;
    localparam int STAT_TC_BIT  = 4;
    localparam logic [BYTE_W-1:0] INTR_BUS_SVC = 8'h10;
endpackage

// File: rtl/xcnt_shadow_regs.sv
// Host-written shadow copies of the count bytes plus the written-once flag
// of the top byte. Assumes one register write per cycle.
module xcnt_shadow_regs #(
    parameter int BYTES  = 3,
    parameter int ADDR_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [xcnt_pkg::BYTE_W-1:0] reg_wdata,
    output logic [BYTES*xcnt_pkg::BYTE_W-1:0] shadow_q,
    output logic                        hi_written_q
);
    import xcnt_pkg::*;

    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BYTES - 1);

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        // Capture a host write into shadow byte i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[i*BYTE_W +: BYTE_W] <= '0;
            end else if (reg_wr && (reg_addr == ADDR_W'(i))) begin
                shadow_q[i*BYTE_W +: BYTE_W] <= reg_wdata;
            end
        end
    end

    // Remember that the top count byte has been written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_written_q <= 1'b0;
        end else if (reg_wr && (reg_addr == HI_ADDR)) begin
            hi_written_q <= 1'b1;
        end
    end
endmodule

// File: rtl/xcnt_live_counter.sv
// Live down-counter with reload, completion and terminal-count flag.
// Priority per cycle: reload, then done, then decrement. Decrement stops at zero.
module xcnt_live_counter #(
    parameter int CNT_W = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reload,
    input  logic [CNT_W-1:0]            shadow,
    input  logic                        done,
    input  logic                        dec,
    input  logic                        cnt_wr,
    output logic [CNT_W-1:0]            live_q,
    output logic                        tc_q,
    output logic [xcnt_pkg::BYTE_W-1:0] intr_q,
    output logic                        side_clr_q
);
    import xcnt_pkg::*;

    logic live_zero;
    logic hit_zero;

    assign live_zero = (live_q == '0);
    assign hit_zero  = dec && (live_q == CNT_W'(1)) && !done && !reload;

    // Update the live count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (reload) begin
            live_q <= shadow;
        end else if (done) begin
            live_q <= '0;
        end else if (dec && !live_zero) begin
            live_q <= live_q - CNT_W'(1);
        end
    end

    // Terminal-count flag: set on completion or reaching zero, cleared by count writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
        end else if (reload) begin
            tc_q <= 1'b0;
        end else if (done || hit_zero) begin
            tc_q <= 1'b1;
        end else if (cnt_wr) begin
            tc_q <= 1'b0;
        end
    end

    // Interrupt code: bus-service on completion, cleared by a reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_q <= '0;
        end else if (reload) begin
            intr_q <= '0;
        end else if (done) begin
            intr_q <= INTR_BUS_SVC;
        end
    end

    // One-cycle pulse to neighbours after an accepted completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_clr_q <= 1'b0;
        end else begin
            side_clr_q <= done && !reload;
        end
    end
endmodule

// File: rtl/xcnt_len_calc.sv
// Effective length (zero means ZERO_LEN) and the length that will move.
// Assumes ZERO_LEN fits in CNT_W bits.
module xcnt_len_calc #(
    parameter int CNT_W    = 24,
    parameter int ZERO_LEN = 65536
) (
    input  logic [CNT_W-1:0] live,
    input  logic [CNT_W-1:0] rem_size,
    output logic [CNT_W-1:0] eff_len,
    output logic [CNT_W-1:0] xfer_len
);
    localparam logic [CNT_W-1:0] ZERO_VAL = CNT_W'(ZERO_LEN);

    // Map a zero count to the full-length value, then clip to the remaining size.
    always_comb begin
        eff_len  = (live == '0) ? ZERO_VAL : live;
        xfer_len = (rem_size < eff_len) ? rem_size : eff_len;
    end
endmodule

// File: rtl/xcnt_top.sv
// Transfer-count register set: shadows, live counter, length calculation
// and the byte-wide register read mux. Reads are combinational from state.
module xcnt_top #(
    parameter int                 BYTES    = 3,
    parameter int                 ADDR_W   = 3,
    parameter int                 ZERO_LEN = 65536,
    parameter logic [7:0]         CHIP_ID  = 8'hA2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  dec_req,
    input  logic                  xfer_done,
    input  logic [BYTES*8-1:0]    rem_size,
    output logic [BYTES*8-1:0]    eff_len_o,
    output logic [BYTES*8-1:0]    xfer_len_o,
    output logic                  term_cnt_o,
    output logic [7:0]            intr_code_o,
    output logic                  side_clr_o
);
    import xcnt_pkg::*;

    localparam int CNT_W = BYTES * BYTE_W;
    localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(BYTES);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(BYTES + 1);
    localparam logic [ADDR_W-1:0] INTR_ADDR = ADDR_W'(BYTES + 2);

    logic [CNT_W-1:0] shadow;
    logic             hi_written;
    logic [CNT_W-1:0] live_cnt;
    logic             tc_flag;
    logic             cmd_reload;
    logic             cnt_wr;

    assign cmd_reload = reg_wr && (reg_addr == CMD_ADDR) && reg_wdata[CMD_DMA_BIT];
    assign cnt_wr     = reg_wr && (reg_addr < ADDR_W'(BYTES));

    xcnt_shadow_regs #(.BYTES(BYTES), .ADDR_W(ADDR_W)) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .shadow_q     (shadow),
        .hi_written_q (hi_written)
    );

    xcnt_live_counter #(.CNT_W(CNT_W)) u_live (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (cmd_reload),
        .shadow     (shadow),
        .done       (xfer_done),
        .dec        (dec_req),
        .cnt_wr     (cnt_wr),
        .live_q     (live_cnt),
        .tc_q       (tc_flag),
        .intr_q     (intr_code_o),
        .side_clr_q (side_clr_o)
    );

    xcnt_len_calc #(.CNT_W(CNT_W), .ZERO_LEN(ZERO_LEN)) u_len (
        .live     (live_cnt),
        .rem_size (rem_size),
        .eff_len  (eff_len_o),
        .xfer_len (xfer_len_o)
    );

    assign term_cnt_o = tc_flag;

    // Register read mux; the top count byte returns the ID until first written.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (reg_addr == ADDR_W'(i)) begin
                if ((i == BYTES - 1) && !hi_written) begin
                    reg_rdata = CHIP_ID;
                end else begin
                    reg_rdata = live_cnt[i*BYTE_W +: BYTE_W];
                end
            end
        end
        if (reg_addr == STAT_ADDR) begin
            reg_rdata[STAT_TC_BIT] = tc_flag;
        end
        if (reg_addr == INTR_ADDR) begin
            reg_rdata = intr_code_o;
        end
    end
endmodule

// File: rtl/xcnt_chk.sv
// Assertion checker for xcnt_top, attached by bind below.
module xcnt_chk #(
    parameter int BYTES    = 3,
    parameter int ADDR_W   = 3,
    parameter int ZERO_LEN = 65536
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [7:0]           reg_wdata,
    input logic                 dec_req,
    input logic                 xfer_done,
    input logic [BYTES*8-1:0]   rem_size,
    input logic [BYTES*8-1:0]   eff_len_o,
    input logic [BYTES*8-1:0]   xfer_len_o,
    input logic                 term_cnt_o,
    input logic [7:0]           intr_code_o,
    input logic                 side_clr_o,
    input logic [BYTES*8-1:0]   live_cnt,
    input logic [BYTES*8-1:0]   shadow
);
    localparam int CNT_W = BYTES * 8;

    logic reload_c;
    logic cnt_wr_c;
    assign reload_c = reg_wr && (reg_addr == ADDR_W'(BYTES)) && reg_wdata[7];
    assign cnt_wr_c = reg_wr && (reg_addr < ADDR_W'(BYTES));

    // R3
    reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_c |=> (live_cnt == $past(shadow)) && !term_cnt_o);

    // R4
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == '0) |-> (eff_len_o == CNT_W'(ZERO_LEN)));

    // R5
    len_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_len_o <= rem_size) && (xfer_len_o <= eff_len_o)
        && ((xfer_len_o == rem_size) || (xfer_len_o == eff_len_o)));

    // R6
    cnt_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr_c && !xfer_done && !(dec_req && live_cnt == CNT_W'(1))) |=> !term_cnt_o);

    // R8
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !reload_c) |=> (live_cnt == '0) && term_cnt_o && (intr_code_o == 8'h10));

    // R8
    side_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        side_clr_o |-> $past(xfer_done));

    // R9
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && live_cnt != '0 && !reload_c && !xfer_done) |=> (live_cnt == $past(live_cnt) - CNT_W'(1)));

    // R10
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && live_cnt == '0 && !reload_c && !xfer_done) |=> (live_cnt == '0) && $stable(term_cnt_o));
endmodule

bind xcnt_top xcnt_chk #(.BYTES(BYTES), .ADDR_W(ADDR_W), .ZERO_LEN(ZERO_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .dec_req     (dec_req),
    .xfer_done   (xfer_done),
    .rem_size    (rem_size),
    .eff_len_o   (eff_len_o),
    .xfer_len_o  (xfer_len_o),
    .term_cnt_o  (term_cnt_o),
    .intr_code_o (intr_code_o),
    .side_clr_o  (side_clr_o),
    .live_cnt    (live_cnt),
    .shadow      (shadow)
);

// File: tb/xcnt_top_tb_top.sv
`timescale 1ns/1ps
module xcnt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        dec_req = 1'b0;
    logic        xfer_done = 1'b0;
    logic [23:0] rem_size = 24'hFFFFFF;
    logic [23:0] eff_len_o;
    logic [23:0] xfer_len_o;
    logic        term_cnt_o;
    logic [7:0]  intr_code_o;
    logic        side_clr_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xcnt_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_req(dec_req),
        .xfer_done(xfer_done), .rem_size(rem_size), .eff_len_o(eff_len_o),
        .xfer_len_o(xfer_len_o), .term_cnt_o(term_cnt_o),
        .intr_code_o(intr_code_o), .side_clr_o(side_clr_o)
    );

    // Row: {read(1)/write(0), requirement tag, address, data or expected}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 4'd2, 3'd0, 8'h03},
        {1'b1, 4'd2, 3'd0, 8'h00},
        {1'b0, 4'd2, 3'd1, 8'h02},
        {1'b0, 4'd7, 3'd2, 8'h01},
        {1'b1, 4'd7, 3'd2, 8'h00},
        {1'b0, 4'd3, 3'd3, 8'h00},
        {1'b1, 4'd3, 3'd0, 8'h00},
        {1'b0, 4'd3, 3'd3, 8'h80},
        {1'b1, 4'd1, 3'd0, 8'h03},
        {1'b1, 4'd1, 3'd1, 8'h02},
        {1'b1, 4'd1, 3'd2, 8'h01},
        {1'b1, 4'd3, 3'd4, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called just after a rising edge; completes after the next edge + 1 ns.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a; #0.2;
        chk(req, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11 reset state
        rd("R11", 3'd0, 8'h00);
        rd("R11", 3'd5, 8'h00);
        chk("R11", {31'h0, term_cnt_o}, 32'h0);
        chk("R11", {31'h0, side_clr_o}, 32'h0);
        // R7 identification read after reset
        rd("R7", 3'd2, 8'hA2);
        // R4 zero live count means 65536
        chk("R4", {8'h0, eff_len_o}, 32'h10000);
        rem_size = 24'h020000; #0.2;
        chk("R5", {8'h0, xfer_len_o}, 32'h10000);
        rem_size = 24'hFFFFFF;

        // R7 a low-byte write does not end the identification read
        wr(3'd0, 8'h55);
        rd("R7", 3'd2, 8'hA2);

        // Vector table walk (R1 R2 R3 R7)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][15]) begin
                rd($sformatf("R%0d", VEC[i][14:11]), VEC[i][10:8], VEC[i][7:0]);
            end else begin
                wr(VEC[i][10:8], VEC[i][7:0]);
            end
        end
        // R1 composition of the effective count
        chk("R1", {8'h0, eff_len_o}, 32'h010203);
        // R5 clipping both ways
        rem_size = 24'h000100; #0.2;
        chk("R5", {8'h0, xfer_len_o}, 32'h100);
        rem_size = 24'hFFFFFF; #0.2;
        chk("R5", {8'h0, xfer_len_o}, 32'h010203);

        // R9 countdown to terminal count
        wr(3'd0, 8'h02); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h80);
        chk("R9", {8'h0, eff_len_o}, 32'h2);
        dec_req = 1'b1; tick();
        chk("R9", {8'h0, eff_len_o}, 32'h1);
        chk("R9", {31'h0, term_cnt_o}, 32'h0);
        tick();
        dec_req = 1'b0;
        rd("R9", 3'd0, 8'h00);
        chk("R9", {31'h0, term_cnt_o}, 32'h1);
        rd("R9", 3'd4, 8'h10);
        // R10 decrement at zero ignored
        dec_req = 1'b1; tick(); tick(); dec_req = 1'b0;
        rd("R10", 3'd0, 8'h00);
        chk("R10", {8'h0, eff_len_o}, 32'h10000);
        chk("R10", {31'h0, term_cnt_o}, 32'h1);

        // R6 count write clears terminal count; live stays zero
        wr(3'd1, 8'h00);
        rd("R6", 3'd4, 8'h00);
        chk("R6", {31'h0, term_cnt_o}, 32'h0);
        rd("R6", 3'd0, 8'h00);

        // R8 completion
        wr(3'd0, 8'h05); wr(3'd3, 8'h80);
        rd("R8", 3'd0, 8'h05);
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        rd("R8", 3'd0, 8'h00);
        chk("R8", {31'h0, term_cnt_o}, 32'h1);
        rd("R8", 3'd5, 8'h10);
        chk("R8", {31'h0, side_clr_o}, 32'h1);
        tick();
        chk("R8", {31'h0, side_clr_o}, 32'h0);

        // R12 reload beats done
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h80; xfer_done = 1'b1;
        tick();
        reg_wr = 1'b0; xfer_done = 1'b0;
        rd("R12", 3'd0, 8'h05);
        chk("R12", {31'h0, term_cnt_o}, 32'h0);
        rd("R12", 3'd5, 8'h00);
        chk("R12", {31'h0, side_clr_o}, 32'h0);
        // R12 done beats decrement
        dec_req = 1'b1; xfer_done = 1'b1; tick();
        dec_req = 1'b0; xfer_done = 1'b0;
        rd("R12", 3'd0, 8'h00);
        chk("R12", {31'h0, term_cnt_o}, 32'h1);
        // R12 reload beats decrement
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h80; dec_req = 1'b1;
        tick();
        reg_wr = 1'b0; dec_req = 1'b0;
        rd("R12", 3'd0, 8'h05);
        // R3 command without DMA flag keeps live count
        wr(3'd0, 8'h09); wr(3'd3, 8'h01);
        rd("R3", 3'd0, 8'h05);

        // R11 / R7 reset clears written-once state and shadows
        do_reset();
        rd("R7", 3'd2, 8'hA2);
        wr(3'd3, 8'h80);
        rd("R11", 3'd0, 8'h00);
        wr(3'd2, 8'h07);
        rd("R7", 3'd2, 8'h00);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule